// File: doc/BRIEF.md
# Block-Read Tile Buffer

This block is an on-chip store for one square tile of 8-bit luma samples, 64 by 64 by default (4 KB). A host fills it with short horizontal runs: each write places four neighbouring pixels of one row at a column that is a multiple of four. A motion-search datapath reads it as two-dimensional 4×4 blocks. All sixteen pixels of a block come back together, and a new block can be requested on every cycle.

Storage is split into four row banks, chosen by the row index modulo four. Any four consecutive rows therefore touch each bank exactly once. Each bank supplies its row for the block. The four rows are then rotated so that the top row of the block comes first, and the result is registered. A typical encoder uses two instances: one for the current tile and one for the reference tile.

Top module: `blk_frame_buf`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted read, `rd_valid` is 0 and `rd_pix` is all zeros.
- R2: A write with `wr_en` high stores lane i of `wr_pix` (bits i*8+7..i*8, i = 0..3) at row `wr_row`, column `wr_seg`*4+i. Every other pixel of the tile keeps its value.
- R3: A read with origin (`rd_x`, `rd_y`), each in 0..60, returns rows `rd_y`..`rd_y`+3 and columns `rd_x`..`rd_x`+3 for any alignment. Pixel (r, c) of the block is placed at `rd_pix`[(r*4+c)*8 +: 8], with row 0 at the lowest bits whatever `rd_y` mod 4 is.
- R4: An accepted read raises `rd_valid` on the next clock edge, and the block data is presented on that same edge.
- R5: Reads may be issued on consecutive cycles. Each one returns its own block one cycle later.
- R6: A read with `rd_x` > 60 or `rd_y` > 60 is rejected. `rd_valid` stays 0 in the following cycle and `rd_pix` is unchanged.
- R7: In a cycle with no accepted read, `rd_pix` holds its previous value and `rd_valid` is 0.
- R8: When a read and a write touch the same pixel in the same cycle, the read returns the value stored before the write. A later read returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_row | input | 6 | Row of the write |
| wr_seg | input | 4 | Column segment of the write (column = wr_seg*4) |
| wr_pix | input | 32 | Four pixels, lane 0 leftmost |
| rd_en | input | 1 | Block read request |
| rd_x | input | 6 | Left column of the block |
| rd_y | input | 6 | Top row of the block |
| rd_valid | output | 1 | Block data valid |
| rd_pix | output | 128 | 16 pixels, row-major |

## Verification
The bench builds the block with its default parameters: a 64-pixel tile side, 4-row blocks and 8-bit pixels. This size lets a full fill of the tile and a read at the far legal corner (60, 60) run quickly. Block origins cover all four values of the row index modulo four, so every rotation of the bank outputs is used. Origins just past the limit (61 and 63) are also applied, to exercise the rejection path.

// File: rtl/blk_frame_buf.sv
module blk_frame_buf #(
  parameter int TILE  = 64,
  parameter int BLK   = 4,
  parameter int PIX_W = 8,
  localparam int ROW_W      = $clog2(TILE),
  localparam int SEG_W      = $clog2(TILE / BLK),
  localparam int SEG_BITS   = BLK * PIX_W,
  localparam int BLOCK_BITS = BLK * BLK * PIX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      wr_row,
  input  logic [SEG_W-1:0]      wr_seg,
  input  logic [SEG_BITS-1:0]   wr_pix,
  input  logic                  rd_en,
  input  logic [ROW_W-1:0]      rd_x,
  input  logic [ROW_W-1:0]      rd_y,
  output logic                  rd_valid,
  output logic [BLOCK_BITS-1:0] rd_pix
);
  localparam int BI     = $clog2(BLK);
  localparam int DEPTH  = TILE / BLK;
  localparam int DW     = $clog2(DEPTH);
  localparam int LINE_W = TILE * PIX_W;
  localparam int LIMIT  = TILE - BLK;

  logic                rd_ok;
  logic [ROW_W-1:0]    col;
  logic [SEG_BITS-1:0] bank_seg [BLK];

  assign rd_ok = rd_en && (rd_x <= ROW_W'(LIMIT)) && (rd_y <= ROW_W'(LIMIT));
  assign col   = (rd_x <= ROW_W'(LIMIT)) ? rd_x : '0;

  for (genvar b = 0; b < BLK; b++) begin : g_bank
    logic [LINE_W-1:0] mem [DEPTH];
    logic [BI-1:0]     k;
    logic [DW-1:0]     ra;

    always_ff @(posedge clk)
      if (wr_en && wr_row[BI-1:0] == BI'(b))
        mem[wr_row[ROW_W-1:BI]][wr_seg*SEG_BITS +: SEG_BITS] <= wr_pix;

    assign k  = BI'(b) - rd_y[BI-1:0];
    assign ra = DW'((rd_y + ROW_W'(k)) >> BI);
    assign bank_seg[b] = mem[ra][col*PIX_W +: SEG_BITS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_pix   <= '0;
    end else begin
      rd_valid <= rd_ok;
      if (rd_ok)
        for (int k = 0; k < BLK; k++)
          rd_pix[k*SEG_BITS +: SEG_BITS] <= bank_seg[BI'(rd_y[BI-1:0] + BI'(k))];
    end
  end
endmodule

// File: rtl/blk_frame_buf_chk.sv
module blk_frame_buf_chk #(
  parameter int TILE  = 64,
  parameter int BLK   = 4,
  parameter int PIX_W = 8,
  localparam int ROW_W      = $clog2(TILE),
  localparam int BLOCK_BITS = BLK * BLK * PIX_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_en,
  input logic [ROW_W-1:0]      rd_x,
  input logic [ROW_W-1:0]      rd_y,
  input logic                  rd_valid,
  input logic [BLOCK_BITS-1:0] rd_pix
);
  localparam logic [ROW_W-1:0] LIM = ROW_W'(TILE - BLK);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && rd_pix == '0));

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_x <= LIM && rd_y <= LIM) |=> rd_valid);

  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_x > LIM || rd_y > LIM)) |=> (!rd_valid && $stable(rd_pix)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_pix)));

  a_r7_no_valid_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_pix) || $rose(rst_n) || $past(rd_en));
endmodule

bind blk_frame_buf blk_frame_buf_chk #(.TILE(TILE), .BLK(BLK), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
  .rd_valid(rd_valid), .rd_pix(rd_pix)
);

// File: tb/blk_frame_buf_test.sv
`timescale 1ns/1ps
module blk_frame_buf_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_row = '0;
  logic [3:0]   wr_seg = '0;
  logic [31:0]  wr_pix = '0;
  logic         rd_en = 1'b0;
  logic [5:0]   rd_x = '0;
  logic [5:0]   rd_y = '0;
  logic         rd_valid;
  logic [127:0] rd_pix;

  int runs = 0;
  int fails = 0;
  logic [7:0] model [64][64];

  always #5 clk = ~clk;

  blk_frame_buf uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_seg(wr_seg),
    .wr_pix(wr_pix), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
    .rd_valid(rd_valid), .rd_pix(rd_pix)
  );

  localparam logic [5:0] RV [10][2] = '{
    '{6'd0, 6'd0}, '{6'd4, 6'd4}, '{6'd1, 6'd2}, '{6'd60, 6'd60}, '{6'd0, 6'd60},
    '{6'd60, 6'd0}, '{6'd33, 6'd17}, '{6'd7, 6'd3}, '{6'd58, 6'd41}, '{6'd13, 6'd30}
  };

  function automatic logic [7:0] pat(int r, int c);
    return 8'((r * 7 + c * 13 + 5) & 255);
  endfunction

  function automatic logic [127:0] exp_blk(int x, int y);
    logic [127:0] v = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        v[(r*4+c)*8 +: 8] = model[y+r][x+c];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int r, int s, logic [31:0] d);
    wr_en = 1'b1; wr_row = 6'(r); wr_seg = 4'(s); wr_pix = d;
    for (int i = 0; i < 4; i++) model[r][s*4+i] = d[i*8 +: 8];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int x, int y, string req);
    logic [127:0] e = exp_blk(x, y);
    rd_en = 1'b1; rd_x = 6'(x); rd_y = 6'(y);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid && rd_pix == e, req, rd_pix, e);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [127:0] held;
    logic [127:0] e;
    repeat (3) @(negedge clk);
    chk(!rd_valid && rd_pix == '0, "R1 in reset", rd_pix, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && rd_pix == '0, "R1 after reset", rd_pix, '0);

    for (int r = 0; r < 64; r++)
      for (int s = 0; s < 16; s++)
        wr(r, s, {pat(r, s*4+3), pat(r, s*4+2), pat(r, s*4+1), pat(r, s*4)});

    for (int i = 0; i < 10; i++)
      rd(int'(RV[i][0]), int'(RV[i][1]), "R3/R4 table read");

    // R5 back-to-back reads
    rd_en = 1'b1; rd_x = 6'd9; rd_y = 6'd1;
    for (int i = 0; i < 4; i++) begin
      e = exp_blk(9 + i, 1 + i);
      @(negedge clk);
      chk(rd_valid && rd_pix == e, "R5 streaming read", rd_pix, e);
      rd_x = 6'(10 + i); rd_y = 6'(2 + i);
    end
    rd_en = 1'b0;
    @(negedge clk);

    // R7 idle hold
    held = rd_pix;
    repeat (2) @(negedge clk);
    chk(!rd_valid && rd_pix == held, "R7 idle hold", rd_pix, held);

    // R6 out of range
    rd_en = 1'b1; rd_x = 6'd61; rd_y = 6'd0;
    @(negedge clk);
    chk(!rd_valid && rd_pix == held, "R6 x=61 rejected", rd_pix, held);
    rd_x = 6'd0; rd_y = 6'd63;
    @(negedge clk);
    rd_en = 1'b0;
    chk(!rd_valid && rd_pix == held, "R6 y=63 rejected", rd_pix, held);

    // R2 partial write keeps neighbours
    wr(21, 5, 32'hDEADBEEF);
    rd(18, 19, "R2 segment written, neighbours kept");
    chk(model[21][20] == 8'hEF && model[21][19] == pat(21, 19), "R2 model lanes",
        {120'd0, model[21][20]}, {120'd0, 8'hEF});

    // R8 same-cycle read and write
    e = exp_blk(8, 10);
    wr_en = 1'b1; wr_row = 6'd10; wr_seg = 4'd2; wr_pix = 32'h11223344;
    rd_en = 1'b1; rd_x = 6'd8; rd_y = 6'd10;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid && rd_pix == e, "R8 old data on collision", rd_pix, e);
    for (int i = 0; i < 4; i++) model[10][8+i] = wr_pix[i*8 +: 8];
    rd(8, 10, "R8 new data afterwards");

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule